// File: doc/BRIEF.md
# Multi-Channel Transmit Phase-Compensation FIFO

This block carries parallel transmit words for four channels from their write clock domains into a single reference clock domain. Every write clock has the same frequency as the reference clock. Its phase relative to the reference is unknown but fixed. Each channel has a small elastic buffer that absorbs this phase offset. The buffer also absorbs a limited amount of slow drift that may appear later.

Each channel word is 10 bits wide. It holds eight user data bits, a control-character request flag and a start-of-frame flag. A mode input selects how the buffers are written:

- each channel with its own write clock, or
- all four channels with one common clock. The common clock is either channel A's write clock or the reference clock.

The read side always runs on the reference clock. The read and write pointers are aligned only when reset is released. If a channel's drift exceeds its margin, that channel raises a sticky error flag, which only a reset clears.

Top module: `txphase_fifo_bank`

## Requirements
- R1: Each 10-bit word passes through unchanged, with its field layout intact. Bits [7:0] are user data, bit [8] is the control-character flag and bit [9] is the start-of-frame flag.
- R2: With `lock_en` = 0, the buffer of channel i is written on the rising edges of `wr_clk[i]`.
- R3: With `lock_en` = 1 and `lock_ref` = 0, all four buffers are written on the rising edges of `wr_clk[0]`. The other write clocks have no effect.
- R4: With `lock_en` = 1 and `lock_ref` = 1, all four buffers are written on the rising edges of `ref_clk`. None of the write clocks has any effect.
- R5: The read side runs only on `ref_clk`. For any fixed write phase, each channel delivers its words in order, with no word lost and no word repeated.
- R6: While `rst_n` is low at a `ref_clk` edge, all output words are driven to zero and all error flags are cleared. After reset is released, the outputs stay zero until the channel has aligned.
- R7: Alignment happens only after reset is released. The read pointer is loaded from the synchronized write pointer, which leaves about two entries of slack. A one-time phase step of 3 ns after alignment causes no error and no break in the data.
- R8: Write pointers cross into the reference domain as Gray code through two flip-flops. The registered Gray pointer changes by at most one bit per write clock edge.
- R9: The error flag of a channel is raised when the observed distance between its pointers has moved half the buffer depth away from the distance seen right after alignment. Once raised, the flag stays high until reset.
- R10: Error detection is independent for each channel. Drift on one channel does not raise the flag of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; read side of every channel |
| rst_n | input | 1 | Active-low reset, sampled synchronously; pointers align when it is released |
| lock_en | input | 1 | 1 = one common write clock for all channels, 0 = one write clock per channel |
| lock_ref | input | 1 | When `lock_en` = 1: 1 = reference clock is the common clock, 0 = channel A's write clock |
| wr_clk | input | 4 | Write clock of each channel; bit 0 is channel A |
| wr_word | input | 40 | Write words; channel i occupies bits [10i+9:10i] |
| rd_word | output | 40 | Words in the reference domain; channel i occupies bits [10i+9:10i] |
| rd_err | output | 4 | Sticky drift-margin error flag for each channel |

## Verification
The bench builds the block with its default values: four channels, a 10-bit word and a buffer depth of four. With a depth of four, a drift of two words is enough to reach the error threshold. A write clock that runs 1% slow therefore trips the flag of its channel within a few hundred cycles. The four write clocks start at different phase offsets, so every channel crosses the clock domains at a different sampling point. Each of the three write-clock selections is tested with the write clocks it should ignore stopped.

// File: rtl/txpf_pkg.sv
`timescale 1ns/1ps
// Package txpf_pkg
// Purpose: shared word layout and read-side state encoding for the
//          transmit phase-compensation FIFO bank.
// Assumes: nothing beyond IEEE 1800-2017.
package txpf_pkg;
    localparam int WORD_W   = 10;
    localparam int DATA_W   = 8;
    localparam int KFLAG_IX = 8;
    localparam int SOF_IX   = 9;

    typedef enum logic {
        ST_ALIGN  = 1'b0,
        ST_STREAM = 1'b1
    } rd_state_e;
endpackage

// File: rtl/txpf_clk_pick.sv
`timescale 1ns/1ps
// Module txpf_clk_pick
// Purpose: chooses the write clock of each channel from the mode inputs:
//          its own clock, channel A's clock, or the reference clock.
// Assumes: mode inputs change only while the bank is held in reset, so a
//          glitch on the chosen clock only disturbs state that reset clears.
module txpf_clk_pick #(
    parameter int NCH = 4
) (
    input  logic           ref_clk,
    input  logic           lock_en,
    input  logic           lock_ref,
    input  logic [NCH-1:0] wr_clk,
    output logic [NCH-1:0] wclk_sel
);
    logic common_clk;

    // common clock used in channel-lock mode
    always_comb common_clk = lock_ref ? ref_clk : wr_clk[0];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_pick
        // per-channel choice between own clock and the common clock
        always_comb wclk_sel[ch] = lock_en ? common_clk : wr_clk[ch];
    end
endmodule

// File: rtl/txpf_wr_side.sv
`timescale 1ns/1ps
// Module txpf_wr_side
// Purpose: write half of one channel buffer. It brings the reset into the
//          write clock domain, writes one word on every edge and publishes
//          its pointer in Gray code.
// Assumes: the write clock runs continuously whenever data must flow;
//          DEPTH is a power of two, at least 4.
module txpf_wr_side #(
    parameter int W     = 10,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               wclk,
    input  logic               rst_n,
    input  logic [W-1:0]       din,
    output logic [AW-1:0]      wgray_o,
    output logic [DEPTH*W-1:0] mem_o
);
    logic [1:0]    rst_pipe;
    logic          wrst_n;
    logic [AW-1:0] wbin;
    logic [AW-1:0] wbin_nx;
    logic [AW-1:0] wgray;
    logic [W-1:0]  mem [DEPTH];

    // two-stage synchronizer carrying the reset into the write domain
    always_ff @(posedge wclk) rst_pipe <= {rst_pipe[0], rst_n};
    assign wrst_n = rst_pipe[1];

    // next binary write address
    always_comb wbin_nx = wbin + AW'(1);

    // write pointer, binary and Gray registered together
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // one word stored per write edge once out of reset
    always_ff @(posedge wclk) begin
        if (wrst_n) mem[wbin] <= din;
    end

    // flatten storage for the read side
    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_o[i*W +: W] = mem[i];
    end

    assign wgray_o = wgray;

    // R8: the Gray pointer toggles at most one bit per write edge
    p_gray_step_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/txpf_gray_sync.sv
`timescale 1ns/1ps
// Module txpf_gray_sync
// Purpose: two flip-flop synchronizer that brings a Gray-coded pointer into
//          the reference clock domain.
// Assumes: the input changes by at most one bit between samples.
module txpf_gray_sync #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    logic [AW-1:0] stage1;

    // two flops in series, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/txpf_rd_side.sv
`timescale 1ns/1ps
// Module txpf_rd_side
// Purpose: read half of one channel buffer on the reference clock.
//          After reset it waits for the first sign of write progress and
//          loads the read pointer from it. It then streams one word per
//          cycle and watches the pointer distance for drift.
// Assumes: the write pointer arrives already synchronized, in Gray code.
module txpf_rd_side
    import txpf_pkg::*;
#(
    parameter int W     = 10,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      wgray_s,
    input  logic [DEPTH*W-1:0] mem_i,
    output logic [W-1:0]       word_o,
    output logic               err_o
);
    localparam logic [AW-1:0] ERR_GAP = AW'((1 + DEPTH/2) % DEPTH);

    rd_state_e     state;
    logic [AW-1:0] wbin_s;
    logic [AW-1:0] rptr;
    logic [AW-1:0] gap;
    logic [W-1:0]  word_q;
    logic          err_q;

    // Gray to binary conversion of the synchronized write pointer
    always_comb begin
        for (int i = 0; i < AW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    // observed distance between the write and read pointers
    always_comb gap = wbin_s - rptr;

    // alignment, streaming and sticky drift detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_ALIGN;
            rptr   <= '0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_ALIGN: begin
                    if (wbin_s != '0) begin
                        rptr  <= wbin_s;
                        state <= ST_STREAM;
                    end
                end
                default: begin
                    word_q <= mem_i[int'(rptr)*W +: W];
                    rptr   <= rptr + AW'(1);
                    if (gap == ERR_GAP) err_q <= 1'b1;
                end
            endcase
        end
    end

    assign word_o = word_q;
    assign err_o  = err_q;

    // R6: reset forces an idle word and a clear flag
    p_idle_in_reset_r6: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0 && !err_q));

    // R6: no data leaves before alignment has completed
    p_idle_until_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN) |-> (word_q == '0));

    // R9: once raised, the flag holds until reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_o);

    // R9: the flag follows a margin violation seen while streaming
    p_err_on_margin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && gap == ERR_GAP) |=> err_o);
endmodule

// File: rtl/txphase_fifo_bank.sv
`timescale 1ns/1ps
// Module txphase_fifo_bank
// Purpose: four-channel transmit phase-compensation FIFO. Words enter on
//          the selected write clock of each channel and leave on the
//          reference clock through a small elastic buffer per channel.
// Assumes: every write clock is frequency-locked to ref_clk; mode inputs
//          change only during reset; rst_n is sampled on ref_clk.
module txphase_fifo_bank
    import txpf_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int W     = WORD_W,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             lock_en,
    input  logic             lock_ref,
    input  logic [NCH-1:0]   wr_clk,
    input  logic [NCH*W-1:0] wr_word,
    output logic [NCH*W-1:0] rd_word,
    output logic [NCH-1:0]   rd_err
);
    logic [NCH-1:0] wclk_sel;

    txpf_clk_pick #(.NCH(NCH)) u_pick (
        .ref_clk  (ref_clk),
        .lock_en  (lock_en),
        .lock_ref (lock_ref),
        .wr_clk   (wr_clk),
        .wclk_sel (wclk_sel)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [AW-1:0]      wgray;
        logic [AW-1:0]      wgray_s;
        logic [DEPTH*W-1:0] mem;

        txpf_wr_side #(.W(W), .DEPTH(DEPTH)) u_wr (
            .wclk    (wclk_sel[ch]),
            .rst_n   (rst_n),
            .din     (wr_word[ch*W +: W]),
            .wgray_o (wgray),
            .mem_o   (mem)
        );

        txpf_gray_sync #(.AW(AW)) u_sync (
            .clk   (ref_clk),
            .rst_n (rst_n),
            .d     (wgray),
            .q     (wgray_s)
        );

        txpf_rd_side #(.W(W), .DEPTH(DEPTH)) u_rd (
            .clk     (ref_clk),
            .rst_n   (rst_n),
            .wgray_s (wgray_s),
            .mem_i   (mem),
            .word_o  (rd_word[ch*W +: W]),
            .err_o   (rd_err[ch])
        );
    end
endmodule

// File: tb/txphase_fifo_bank_test.sv
`timescale 1ns/1ps
module txphase_fifo_bank_test;
    localparam int NCH = 4;
    localparam int W   = 10;

    logic             ref_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             lock_en = 1'b0;
    logic             lock_ref = 1'b0;
    logic [NCH-1:0]   wck;
    logic [NCH*W-1:0] wr_word;
    logic [NCH*W-1:0] rd_word;
    logic [NCH-1:0]   rd_err;

    int n_run  = 0;
    int n_fail = 0;

    always #5 ref_clk = ~ref_clk;

    txphase_fifo_bank uut (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .lock_en  (lock_en),
        .lock_ref (lock_ref),
        .wr_clk   (wck),
        .wr_word  (wr_word),
        .rd_word  (rd_word),
        .rd_err   (rd_err)
    );

    function automatic logic [W-1:0] mkword(input logic [7:0] c);
        return {c[3], c[2], c};
    endfunction

    // per-channel write clock, stimulus source and order monitor
    for (genvar g = 0; g < NCH; g++) begin : g_ck
        real  half  = 5.0;
        real  extra = 0.0;
        bit   on    = 1'b1;
        logic ck    = 1'b0;
        logic drv;
        logic [7:0] cnt = 8'd1;
        int   mism = 0;
        int   good = 0;
        bit   started = 1'b0;
        logic [7:0] prev = 8'd0;

        assign wck[g] = ck;

        initial begin
            #(1.3 + 2.4 * g);
            forever begin
                if (on) ck = ~ck;
                #(half);
                if (extra != 0.0) begin
                    #(extra);
                    extra = 0.0;
                end
            end
        end

        // clock the stimulus from the clock the requirements say is in use
        always_comb drv = lock_en ? (lock_ref ? ref_clk : wck[0]) : ck;

        always @(negedge drv) cnt <= rst_n ? cnt + 8'd1 : 8'd1;

        assign wr_word[g*W +: W] = mkword(cnt);

        always @(negedge ref_clk) begin
            if (!rst_n) begin
                started = 1'b0;
            end else if (started || rd_word[g*W +: W] != '0) begin
                if (started) begin
                    if (rd_word[g*W +: W] != mkword(prev + 8'd1)) mism++;
                    else good++;
                end
                started = 1'b1;
                prev = rd_word[g*W +: W][7:0];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        g_ck[0].mism = 0; g_ck[0].good = 0;
        g_ck[1].mism = 0; g_ck[1].good = 0;
        g_ck[2].mism = 0; g_ck[2].good = 0;
        g_ck[3].mism = 0; g_ck[3].good = 0;
    endtask

    task automatic all_on(input bit v);
        g_ck[0].on = v; g_ck[1].on = v; g_ck[2].on = v; g_ck[3].on = v;
    endtask

    task automatic do_reset(input bit lk, input bit rf);
        @(negedge ref_clk);
        rst_n = 1'b0;
        lock_en = lk;
        lock_ref = rf;
        repeat (12) @(negedge ref_clk);
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
    endtask

    task automatic check_stream(input string req);
        int mm[NCH];
        int gd[NCH];
        mm[0] = g_ck[0].mism; gd[0] = g_ck[0].good;
        mm[1] = g_ck[1].mism; gd[1] = g_ck[1].good;
        mm[2] = g_ck[2].mism; gd[2] = g_ck[2].good;
        mm[3] = g_ck[3].mism; gd[3] = g_ck[3].good;
        for (int c = 0; c < NCH; c++) begin
            chk(mm[c] == 0 && gd[c] > 250, req,
                $sformatf("R1 R5 R8 ordered words ch%0d (good=%0d)", c, gd[c]),
                mm[c], 0);
        end
        chk(rd_err == '0, req, "no error flags", int'(rd_err), 0);
    endtask

    // R6: idle outputs and clear flags during reset, after traffic
    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk(rd_word == '0, "R6", "output idle in reset", int'(rd_word[9:0]), 0);
        chk(rd_err == '0, "R6", "flags clear in reset", int'(rd_err), 0);
        release_reset();
    endtask

    // R2 R5 R7: per-channel clocks at four distinct phases
    task automatic t_normal();
        all_on(1'b1);
        do_reset(1'b0, 1'b0);
        release_reset();
        repeat (40) @(negedge ref_clk);
        clear_mon();
        repeat (300) @(negedge ref_clk);
        check_stream("R2 R7");
    endtask

    // R3: channel A clock drives all; the other clocks are stopped
    task automatic t_lock_a();
        all_on(1'b1);
        g_ck[1].on = 1'b0; g_ck[2].on = 1'b0; g_ck[3].on = 1'b0;
        do_reset(1'b1, 1'b0);
        release_reset();
        repeat (40) @(negedge ref_clk);
        clear_mon();
        repeat (300) @(negedge ref_clk);
        check_stream("R3");
        all_on(1'b1);
    endtask

    // R4: reference clock drives all; every write clock is stopped
    task automatic t_lock_ref();
        all_on(1'b0);
        do_reset(1'b1, 1'b1);
        release_reset();
        repeat (40) @(negedge ref_clk);
        clear_mon();
        repeat (300) @(negedge ref_clk);
        check_stream("R4");
        all_on(1'b1);
    endtask

    // R7: a 3 ns phase step after alignment is absorbed
    task automatic t_shift();
        do_reset(1'b0, 1'b0);
        release_reset();
        repeat (40) @(negedge ref_clk);
        clear_mon();
        g_ck[1].extra = 3.0;
        repeat (300) @(negedge ref_clk);
        chk(g_ck[1].mism == 0 && g_ck[1].good > 250, "R7",
            "ch1 order after phase step", g_ck[1].mism, 0);
        chk(rd_err == '0, "R7", "no flag after phase step", int'(rd_err), 0);
    endtask

    // R9 R10: slow clock on channel 2 trips only its flag, which sticks
    task automatic t_drift();
        do_reset(1'b0, 1'b0);
        release_reset();
        repeat (40) @(negedge ref_clk);
        g_ck[2].half = 5.05;
        repeat (1000) @(negedge ref_clk);
        chk(rd_err[2] == 1'b1, "R9", "ch2 flag after drift", int'(rd_err[2]), 1);
        chk((rd_err & 4'b1011) == '0, "R10", "other flags stay clear",
            int'(rd_err), 4);
        g_ck[2].half = 5.0;
        repeat (100) @(negedge ref_clk);
        chk(rd_err[2] == 1'b1, "R9", "ch2 flag sticky", int'(rd_err[2]), 1);
        do_reset(1'b0, 1'b0);
        chk(rd_err == '0, "R9", "reset clears flag", int'(rd_err), 0);
        release_reset();
        repeat (40) @(negedge ref_clk);
    endtask

    initial begin
        #1_500_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0, 1'b0);
        chk(rd_word == '0, "R6", "idle word at start", int'(rd_word[9:0]), 0);
        chk(rd_err == '0, "R6", "clear flags at start", int'(rd_err), 0);
        release_reset();
        t_normal();
        t_reset();
        t_lock_a();
        t_lock_ref();
        t_shift();
        t_drift();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule